// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Controller

This block is a synchronous single-port word memory whose read and write traffic can be interleaved on every active clock edge with no idle cycle between a read and a write. Each word is 18 bits wide, split into two 9-bit lanes. Control, address and lane selects are registered on the rising edge. Read data leaves through an output register. Write data is taken one cycle later than its address ("late write"). Because of this, the data cycle of a write sits exactly where the data cycle of a read would sit, and the shared data bus never has to turn around.

The data port is split into an input word, an output word and a drive-enable for an external tri-state pad. A clock-enable input freezes the whole pipeline. An asynchronous output-enable gates the drive during read data cycles. A load/advance input either starts a new access or continues the previous one as a four-beat wrapping burst, in linear or interleaved order. A forwarding path returns write data that is still in flight to a read of the same word issued one cycle later.

Top module: `zt_sram_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `rdata_drive` is low whatever `drv_en_n` is, and no access is pending.
- R2: A read starts at an active edge k when `tick_en_n`=0, `sel_a_n`=0, `sel_b`=1, `sel_c_n`=0, `load_n`=0 and `wr_n`=1. After edge k+1, `rdata` holds the addressed word, and `rdata_drive` is 1 if `drv_en_n` is 0.
- R3: During a read data cycle, `drv_en_n` gates `rdata_drive` combinationally, with no clock edge involved.
- R4: A write starts like a read but with `wr_n`=0. `wdata` is sampled on the second active edge after the address edge. `lane_wr_n[0]`=0 writes bits 8:0 and `lane_wr_n[1]`=0 writes bits 17:9; a lane whose select is 1 keeps its contents, and 2'b11 writes nothing. Lane selects are sampled together with the address.
- R5: During the data cycle of a write, `rdata_drive` is 0 whatever `drv_en_n` is.
- R6: Reads and writes can follow each other in any mix on consecutive active edges. A read issued one edge after a write to the same word returns the written lanes merged with the old contents of the other lane.
- R7: A load edge with any of the three enables inactive starts no access. After the next active edge `rdata_drive` is 0.
- R8: An edge with `tick_en_n`=1 is ignored: `rdata` and the pipeline hold, nothing is written, and `wdata` on that edge is discarded. A pending write completes on the next active edge.
- R9: An active edge with `load_n`=1 repeats the operation type of the last load at the next burst address. The enables and `wr_n` are ignored on such an edge. The low two address bits become base+n mod 4 when `seq_linear`=1 and base XOR n when `seq_linear`=0; the upper bits stay fixed. Lane selects are sampled on every beat.
- R10: `load_n`=1 after a deselecting load continues the deselect: no access happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en_n | input | 1 | Active-low clock enable; high stalls the block |
| sel_a_n | input | 1 | Enable, active low |
| sel_b | input | 1 | Enable, active high |
| sel_c_n | input | 1 | Enable, active low |
| load_n | input | 1 | Low: start new access; high: advance burst |
| wr_n | input | 1 | Low selects write, high selects read |
| lane_wr_n | input | 2 | Active-low per-lane write selects |
| addr | input | ADDR_W | Word address |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| drv_en_n | input | 1 | Asynchronous active-low output enable |
| wdata | input | 18 | Write data in |
| rdata | output | 18 | Registered read data |
| rdata_drive | output | 1 | Enable for the external data pad driver |

## Verification
Read data and its drive enable are due one active edge after the issuing edge. Write data is consumed on the second active edge after its address, so the bench presents each write word two active slots after the write and checks its effect through later reads. The bench drives inputs just after a rising edge and samples one time unit later. It keeps a two-entry model of the pipeline that shifts only on edges where the clock enable is active, so stall cycles move no expectation. The effect of `drv_en_n` is checked between edges, without a clock.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  // Operation carried through the pipeline stages.
  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10
  } zt_op_e;
endpackage

// File: rtl/zt_sram_cmd.sv
// Address/command stage: decodes a load or a burst advance and registers
// the resulting operation, word address and lane mask.
module zt_sram_cmd
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              load_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              seq_linear,
  output zt_op_e            a_op,
  output logic [ADDR_W-1:0] a_addr,
  output logic [LANES-1:0]  a_lane
);
  localparam int BURST_W = 2;

  logic               chip_sel;
  zt_op_e             kind_q, kind_d;
  logic [ADDR_W-1:0]  base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d;
  logic [BURST_W-1:0] low_d;
  logic [ADDR_W-1:0]  addr_d;

  assign chip_sel = !sel_a_n && sel_b && !sel_c_n;

  always_comb begin
    kind_d = kind_q;
    base_d = base_q;
    cnt_d  = cnt_q + BURST_W'(1);
    if (!load_n) begin
      base_d = addr;
      cnt_d  = '0;
      if (!chip_sel)  kind_d = OP_IDLE;
      else if (wr_n)  kind_d = OP_READ;
      else            kind_d = OP_WRITE;
    end
    if (seq_linear) low_d = base_d[BURST_W-1:0] + cnt_d;
    else            low_d = base_d[BURST_W-1:0] ^ cnt_d;
    addr_d = {base_d[ADDR_W-1:BURST_W], low_d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
      a_op   <= OP_IDLE;
      a_addr <= '0;
      a_lane <= '0;
    end else if (!tick_en_n) begin
      kind_q <= kind_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
      a_op   <= kind_d;
      a_addr <= addr_d;
      a_lane <= ~lane_wr_n;
    end
  end

  // R9: an advance edge reissues the kind held from the last load.
  p_burst_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en_n && load_n) |=> (a_op == $past(kind_q)));

endmodule

// File: rtl/zt_sram_store.sv
// Word storage, one array per lane so that lane writes are independent.
module zt_sram_store #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [LANES-1:0]          wr_lane,
  input  logic [LANE_W*LANES-1:0]   wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [LANE_W*LANES-1:0]   rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_lane[g]) begin
        cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      end
    end

    assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
  end

endmodule

// File: rtl/zt_sram_dpath.sv
// Data stage: holds the operation whose data cycle is in progress, commits
// writes, loads the read register with forwarding, and gates the drive.
module zt_sram_dpath
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_en_n,
  input  logic                     drv_en_n,
  input  zt_op_e                   a_op,
  input  logic [ADDR_W-1:0]        a_addr,
  input  logic [LANES-1:0]         a_lane,
  input  logic [LANE_W*LANES-1:0]  wdata,
  input  logic [LANE_W*LANES-1:0]  arr_q,
  output logic                     wr_en,
  output logic [ADDR_W-1:0]        wr_addr,
  output logic [LANES-1:0]         wr_lane,
  output logic [LANE_W*LANES-1:0]  wr_data,
  output logic [LANE_W*LANES-1:0]  rdata,
  output logic                     rdata_drive
);
  localparam int DATA_W = LANE_W * LANES;

  zt_op_e             b_op_q;
  logic [ADDR_W-1:0]  b_addr_q;
  logic [LANES-1:0]   b_lane_q;
  logic [DATA_W-1:0]  q_q, q_d;
  logic [DATA_W-1:0]  merged;
  logic               fwd_hit;

  assign fwd_hit = (b_op_q == OP_WRITE) && (b_addr_q == a_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    assign merged[g*LANE_W +: LANE_W] = (fwd_hit && b_lane_q[g])
                                      ? wdata[g*LANE_W +: LANE_W]
                                      : arr_q[g*LANE_W +: LANE_W];
  end

  always_comb begin
    q_d = q_q;
    if (a_op == OP_READ) q_d = merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_op_q   <= OP_IDLE;
      b_addr_q <= '0;
      b_lane_q <= '0;
      q_q      <= '0;
    end else if (!tick_en_n) begin
      b_op_q   <= a_op;
      b_addr_q <= a_addr;
      b_lane_q <= a_lane;
      q_q      <= q_d;
    end
  end

  assign wr_en       = (b_op_q == OP_WRITE) && !tick_en_n;
  assign wr_addr     = b_addr_q;
  assign wr_lane     = b_lane_q;
  assign wr_data     = wdata;
  assign rdata       = q_q;
  assign rdata_drive = (b_op_q == OP_READ) && !drv_en_n;

  // R2: an accepted read occupies the data stage one edge later.
  p_read_to_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en_n && a_op == OP_READ) |=> (b_op_q == OP_READ));

  // R5: no drive during the data cycle of a write.
  p_write_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en_n && a_op == OP_WRITE) |=> !rdata_drive);

  // R7: deselect reaches the pad one edge later.
  p_desel_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en_n && a_op == OP_IDLE) |=> !rdata_drive);

  // R6: full-word write followed by a read of that word returns the write data.
  p_forward_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en_n && a_op == OP_READ && fwd_hit && (&b_lane_q)) |=> (rdata == $past(wdata)));

endmodule

// File: rtl/zt_sram_ctrl.sv
module zt_sram_ctrl
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_en_n,
  input  logic                     sel_a_n,
  input  logic                     sel_b,
  input  logic                     sel_c_n,
  input  logic                     load_n,
  input  logic                     wr_n,
  input  logic [LANES-1:0]         lane_wr_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     seq_linear,
  input  logic                     drv_en_n,
  input  logic [LANE_W*LANES-1:0]  wdata,
  output logic [LANE_W*LANES-1:0]  rdata,
  output logic                     rdata_drive
);
  localparam int DATA_W = LANE_W * LANES;

  logic [1:0]         rst_q;
  logic               rst_core_n;
  zt_op_e             a_op;
  logic [ADDR_W-1:0]  a_addr;
  logic [LANES-1:0]   a_lane;
  logic               wr_en;
  logic [ADDR_W-1:0]  wr_addr;
  logic [LANES-1:0]   wr_lane;
  logic [DATA_W-1:0]  wr_data;
  logic [DATA_W-1:0]  arr_q;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_core_n = rst_q[1];

  zt_sram_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) cmd_i (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .tick_en_n  (tick_en_n),
    .sel_a_n    (sel_a_n),
    .sel_b      (sel_b),
    .sel_c_n    (sel_c_n),
    .load_n     (load_n),
    .wr_n       (wr_n),
    .lane_wr_n  (lane_wr_n),
    .addr       (addr),
    .seq_linear (seq_linear),
    .a_op       (a_op),
    .a_addr     (a_addr),
    .a_lane     (a_lane)
  );

  zt_sram_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) store_i (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_lane (wr_lane),
    .wr_data (wr_data),
    .rd_addr (a_addr),
    .rd_data (arr_q)
  );

  zt_sram_dpath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) dpath_i (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .tick_en_n   (tick_en_n),
    .drv_en_n    (drv_en_n),
    .a_op        (a_op),
    .a_addr      (a_addr),
    .a_lane      (a_lane),
    .wdata       (wdata),
    .arr_q       (arr_q),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_lane     (wr_lane),
    .wr_data     (wr_data),
    .rdata       (rdata),
    .rdata_drive (rdata_drive)
  );

  // R8: a stalled edge leaves the read register untouched.
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    tick_en_n |=> $stable(rdata));

  // R8: the array is never written on a stalled edge.
  p_stall_no_write_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    tick_en_n |-> !wr_en);

endmodule

// File: tb/zt_sram_ctrl_tb_top.sv
module zt_sram_ctrl_tb_top;
  localparam int AW    = 4;
  localparam int DW    = 18;
  localparam int DEPTH = 16;
  localparam logic [DW-1:0] JUNK = 18'h2A5A5;
  localparam logic [2:0] ACT = 3'b010;
  localparam logic [2:0] DSL = 3'b111;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, tick_en_n, sel_a_n, sel_b, sel_c_n, load_n, wr_n;
  logic [1:0]    lane_wr_n;
  logic [AW-1:0] addr;
  logic          seq_linear, drv_en_n;
  logic [DW-1:0] wdata, rdata;
  logic          rdata_drive;

  zt_sram_ctrl #(.ADDR_W(AW), .LANE_W(9), .LANES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en_n(tick_en_n), .sel_a_n(sel_a_n),
    .sel_b(sel_b), .sel_c_n(sel_c_n), .load_n(load_n), .wr_n(wr_n),
    .lane_wr_n(lane_wr_n), .addr(addr), .seq_linear(seq_linear),
    .drv_en_n(drv_en_n), .wdata(wdata), .rdata(rdata), .rdata_drive(rdata_drive)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] ref_mem [DEPTH];

  // Pipeline model: op codes 0 idle, 1 read, 2 write.
  int            p1_op, p2_op, p1_a, p2_a;
  logic [1:0]    p1_bwn, p2_bwn;
  logic [DW-1:0] p1_wd, p2_wd, q_hold;
  int            bk_kind, bk_base, bk_cnt;

  function automatic logic [DW-1:0] pat(int a, int salt);
    return DW'(a * 2731 + salt * 977 + 'h2d5);
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic slot(input string req, input bit stall, input bit adv, input logic [2:0] ce,
                      input bit we, input logic [1:0] bwn, input int a,
                      input logic [DW-1:0] wd, input bit oen);
    int na, lo;
    tick_en_n = stall;
    load_n    = adv;
    {sel_a_n, sel_b, sel_c_n} = ce;
    wr_n      = we;
    lane_wr_n = bwn;
    addr      = AW'(a);
    drv_en_n  = oen;
    wdata     = (!stall && p2_op == 2) ? p2_wd : JUNK;
    @(posedge clk);
    #1;
    if (!stall) begin
      if (!adv) begin
        bk_base = a;
        bk_cnt  = 0;
        bk_kind = (ce == ACT) ? (we ? 1 : 2) : 0;
      end else begin
        bk_cnt = (bk_cnt + 1) % 4;
      end
      lo = seq_linear ? (((bk_base % 4) + bk_cnt) % 4) : ((bk_base % 4) ^ bk_cnt);
      na = (bk_base / 4) * 4 + lo;
      if (p2_op == 2) begin
        if (!p2_bwn[0]) ref_mem[p2_a][8:0]  = p2_wd[8:0];
        if (!p2_bwn[1]) ref_mem[p2_a][17:9] = p2_wd[17:9];
      end
      if (p1_op == 1) q_hold = ref_mem[p1_a];
      p2_op = p1_op; p2_a = p1_a; p2_bwn = p1_bwn; p2_wd = p1_wd;
      p1_op = bk_kind; p1_a = na; p1_bwn = bwn; p1_wd = wd;
    end
    chk(req, DW'(rdata_drive), DW'(p2_op == 1 && !oen));
    if (p2_op == 1) chk(req, rdata, q_hold);
  endtask

  task automatic nop(input string req);
    slot(req, 0, 0, DSL, 1, 2'b11, 0, '0, 0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    p1_op = 0; p2_op = 0; p1_a = 0; p2_a = 0; p1_bwn = 2'b11; p2_bwn = 2'b11;
    p1_wd = '0; p2_wd = '0; q_hold = '0; bk_kind = 0; bk_base = 0; bk_cnt = 0;
    rst_n = 0; tick_en_n = 1; sel_a_n = 1; sel_b = 0; sel_c_n = 1; load_n = 0;
    wr_n = 1; lane_wr_n = 2'b11; addr = '0; seq_linear = 1; drv_en_n = 0; wdata = '0;

    // R1: quiet pad during and after reset with output enable asserted.
    repeat (3) @(posedge clk);
    #1;
    chk("R1", DW'(rdata_drive), '0);
    rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", DW'(rdata_drive), '0);

    // R4 / R6: fill every word with back-to-back full writes.
    for (int a = 0; a < DEPTH; a++) slot("R4", 0, 0, ACT, 0, 2'b00, a, pat(a, 1), 0);
    nop("R4"); nop("R4");

    // R2: back-to-back reads of every word.
    for (int a = 0; a < DEPTH; a++) slot("R2", 0, 0, ACT, 1, 2'b00, a, '0, 0);
    nop("R2"); nop("R2");

    // R4: every lane-select pattern, including none.
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 4; a++) slot("R4", 0, 0, ACT, 0, 2'(m), a + 4 * m, pat(a, 20 + m), 0);
      nop("R4"); nop("R4");
      for (int a = 0; a < 4; a++) slot("R4", 0, 0, ACT, 1, 2'b00, a + 4 * m, '0, 0);
      nop("R4"); nop("R4");
    end

    // R6 / R5: write then read of the same word on the next edge, all lane masks.
    for (int a = 0; a < DEPTH; a++) begin
      slot("R5", 0, 0, ACT, 0, 2'(a % 4), a, pat(a, 40), 0);
      slot("R6", 0, 0, ACT, 1, 2'b00, a, '0, 0);
    end
    nop("R6"); nop("R6");
    // R6: read, write, read, write alternation on neighbouring words.
    for (int a = 0; a < 8; a++) begin
      slot("R6", 0, 0, ACT, 1, 2'b00, a, '0, 0);
      slot("R5", 0, 0, ACT, 0, 2'b00, a + 8, pat(a, 50), 0);
    end
    nop("R6"); nop("R6");

    // R3: output enable acts between edges.
    slot("R3", 0, 0, ACT, 1, 2'b00, 3, '0, 0);
    slot("R3", 0, 0, DSL, 1, 2'b11, 0, '0, 1);
    drv_en_n = 0; #1;
    chk("R3", DW'(rdata_drive), DW'(1));
    chk("R3", rdata, ref_mem[3]);
    drv_en_n = 1; #1;
    chk("R3", DW'(rdata_drive), '0);
    nop("R3");

    // R7: each enable alone deselects; the would-be write must not land.
    for (int i = 0; i < 3; i++) begin
      slot("R7", 0, 0, ACT, 1, 2'b00, 2, '0, 0);
      slot("R7", 0, 0, ACT ^ (3'b100 >> i), 0, 2'b00, 5, pat(5, 60 + i), 0);
      nop("R7"); nop("R7");
      slot("R7", 0, 0, ACT, 1, 2'b00, 5, '0, 0);
      nop("R7"); nop("R7");
    end

    // R8: stalls while a read result is shown, and inside a write data cycle.
    slot("R8", 0, 0, ACT, 1, 2'b00, 4, '0, 0);
    slot("R8", 1, 0, ACT, 0, 2'b00, 9, pat(9, 70), 0);
    nop("R8");
    slot("R8", 1, 0, ACT, 0, 2'b00, 9, pat(9, 71), 0);
    slot("R8", 1, 0, ACT, 1, 2'b00, 6, '0, 0);
    nop("R8");
    slot("R8", 0, 0, ACT, 0, 2'b10, 9, pat(9, 72), 0);
    nop("R8");
    slot("R8", 1, 0, DSL, 1, 2'b11, 0, '0, 0);
    slot("R8", 1, 0, DSL, 1, 2'b11, 0, '0, 0);
    nop("R8");
    slot("R8", 0, 0, ACT, 1, 2'b00, 9, '0, 0);
    nop("R8"); nop("R8");

    // R9: bursts in both orders from every start offset.
    for (int lin = 0; lin < 2; lin++) begin
      seq_linear = lin[0];
      for (int st = 0; st < 4; st++) begin
        slot("R9", 0, 0, ACT, 0, 2'b00, 8 + st, pat(st, 80 + lin), 0);
        for (int n = 1; n < 4; n++) slot("R9", 0, 1, DSL, 1, 2'(n), 0, pat(n, 90 + st), 0);
        nop("R9"); nop("R9");
        slot("R9", 0, 0, ACT, 1, 2'b00, 8 + st, '0, 0);
        for (int n = 1; n < 4; n++) slot("R9", 0, 1, DSL, 0, 2'b00, 0, '0, 0);
        nop("R9"); nop("R9");
      end
    end

    // R10: advancing after a deselect stays idle.
    nop("R10");
    for (int n = 0; n < 3; n++) slot("R10", 0, 1, ACT, 0, 2'b00, 6, pat(6, 99), 0);
    nop("R10"); nop("R10");

    // R4: final readback of every word.
    for (int a = 0; a < DEPTH; a++) slot("R4", 0, 0, ACT, 1, 2'b00, a, '0, 0);
    nop("R4"); nop("R4");

    summary();
    $finish;
  end

endmodule